// File: doc/BRIEF.md
# Reset Boot Loader Sequencer

This block decides, once reset is released, how the on-chip program memory gets its first code. It samples three mode pins and picks one of three paths. On the byte-memory path it reads a byte-wide boot memory and packs each group of three bytes into one 24-bit program word. It writes a fixed number of words to program memory from address 0 upward, and holds the core stalled until the last word is written. On the host-port path it writes nothing itself. It watches the writes a host makes through the internal DMA port and holds the core until one of them targets program address 0. Any other pin setting releases the core at once.

While the core is held, the sequencer owns the program-memory write port. When `core_hold` falls, the core starts fetching at program address 0. The byte-memory read port is a request/response pair. A request is raised for one cycle, and the boot memory answers with a valid strobe after any latency.

States: `ST_SAMPLE` (entered in reset; captures the pins), `ST_DISPATCH` (branches on the captured mode), `ST_BYTE_REQ` (issues one byte read), `ST_BYTE_WAIT` (waits for the byte), `ST_WORD_WRITE` (writes one packed word), `ST_HOST_WAIT` (waits for a host write to address 0), `ST_RUN` (core released; terminal). Transitions:
- SAMPLE→DISPATCH on the first edge after release.
- DISPATCH→BYTE_REQ, →HOST_WAIT or →RUN by mode; DISPATCH may also go straight to RUN on a host hit.
- BYTE_REQ→BYTE_WAIT.
- BYTE_WAIT→BYTE_REQ on a non-final byte, and →WORD_WRITE on the third byte.
- WORD_WRITE→BYTE_REQ while words remain, and →RUN after the last word.
- HOST_WAIT→RUN on a host write to address 0.

Top module: `boot_seq_top`

## Requirements
- R1: The mode pins are captured on the first rising clock edge after `rst_n` deasserts. Later changes on the pins have no effect on the boot that follows.
- R2: `mode_pins` is {C,B,A}, with C in bit 2 and A in bit 0. C=0 with A=0 (values 000 and 010) selects byte-memory boot. Value 101 selects host-port boot. The other five values select no boot.
- R3: While `rst_n` is low, `core_hold` is 1 and `bm_rd_en` and `pm_wr_en` are 0.
- R4: Byte-memory boot issues exactly 3×32 = 96 byte reads. Their `bm_addr` values run 0,1,2,…,95 in that order, with the page field (upper bits) at 0.
- R5: Each program word packs three consecutive bytes, first byte in bits 23:16, second in 15:8 and third in 7:0.
- R6: Byte-memory boot makes exactly 32 program-memory writes, to addresses 0,1,…,31 in ascending order.
- R7: In byte-memory boot, `core_hold` stays 1 through every write. It falls in the cycle right after the 32nd write.
- R8: In host-port boot, host writes to non-zero addresses leave `core_hold` at 1, in any number. The block issues no byte reads or program writes of its own. `core_hold` falls in the cycle after a host write to address 0 is sampled, from the second edge after release onward.
- R9: With a no-boot encoding, `core_hold` falls in the cycle after the second edge after release. No reads or writes are made.
- R10: Once `core_hold` has fallen, it stays 0 until the next reset. Host writes, including ones to address 0, then cause no byte reads or program writes.
- R11: Only one byte read is outstanding at a time. The sequencer waits as long as needed for `bm_rd_valid` before it requests the next byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_pins | input | 3 | Boot mode {C,B,A} |
| bm_rd_en | output | 1 | One-cycle byte read request |
| bm_addr | output | 22 | Byte address: page in the upper 8 bits, offset in the lower 14 |
| bm_rd_data | input | 8 | Byte returned by boot memory |
| bm_rd_valid | input | 1 | `bm_rd_data` is valid this cycle |
| pm_wr_en | output | 1 | Program-memory write strobe |
| pm_wr_addr | output | 14 | Program-memory word address |
| pm_wr_data | output | 24 | Program word being written |
| host_wr_en | input | 1 | A host DMA write to program memory occurs this cycle |
| host_wr_addr | input | 14 | Program address of that host write |
| core_hold | output | 1 | Core is stalled while 1 |

## Verification
The properties assume that the boot memory raises `bm_rd_valid` only once for each request and never without one. They also assume that the mode pins keep one value through the edge that releases reset. The bench's memory model answers each request exactly once, after a configurable delay of zero to two extra cycles. The bench changes the pins only while reset is held or after the capture edge. The host-write inputs are driven only in the host-port cases and after release, so they never overlap a byte-memory load.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

    typedef enum logic [2:0] {
        ST_SAMPLE,
        ST_DISPATCH,
        ST_BYTE_REQ,
        ST_BYTE_WAIT,
        ST_WORD_WRITE,
        ST_HOST_WAIT,
        ST_RUN
    } boot_state_e;

    typedef enum logic [1:0] {
        BOOT_BYTE,
        BOOT_HOST,
        BOOT_NONE
    } boot_kind_e;

    // pins are {C,B,A}
    function automatic boot_kind_e decode_mode(input logic [2:0] pins);
        boot_kind_e k;
        if (!pins[2] && !pins[0])
            k = BOOT_BYTE;
        else if (pins == 3'b101)
            k = BOOT_HOST;
        else
            k = BOOT_NONE;
        return k;
    endfunction

endpackage

// File: rtl/boot_mode_capture.sv
module boot_mode_capture
    import boot_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample_en,
    input  logic [2:0] mode_pins,
    output boot_kind_e kind_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            kind_q <= BOOT_NONE;
        else if (sample_en)
            kind_q <= decode_mode(mode_pins);
    end

endmodule

// File: rtl/boot_byte_packer.sv
module boot_byte_packer #(
    parameter int BYTE_W = 8,
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [WORD_W-1:0] word_out,
    output logic              last_byte
);

    localparam int BYTES_PER_WORD = WORD_W / BYTE_W;
    localparam int IDX_W = (BYTES_PER_WORD > 1) ? $clog2(BYTES_PER_WORD) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTES_PER_WORD - 1);

    logic [IDX_W-1:0] idx_q;

    assign last_byte = (idx_q == LAST_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            word_out <= '0;
        end else if (load_en) begin
            word_out <= {word_out[WORD_W-BYTE_W-1:0], byte_in};
            idx_q    <= last_byte ? '0 : idx_q + 1'b1;
        end
    end

endmodule

// File: rtl/boot_dma_regs.sv
module boot_dma_regs #(
    parameter int EXT_AW     = 14,
    parameter int PAGE_W     = 8,
    parameter int PM_AW      = 14,
    parameter int BOOT_WORDS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_step,
    input  logic              word_step,
    output logic [PAGE_W-1:0] page_q,
    output logic [EXT_AW-1:0] ext_addr_q,
    output logic [PM_AW-1:0]  int_addr_q,
    output logic              last_word
);

    localparam int CNT_W = $clog2(BOOT_WORDS + 1);

    logic [CNT_W-1:0] words_left_q;
    logic [EXT_AW:0]  ext_next;

    assign ext_next  = {1'b0, ext_addr_q} + 1'b1;
    assign last_word = (words_left_q == CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q     <= '0;
            ext_addr_q <= '0;
        end else if (byte_step) begin
            ext_addr_q <= ext_next[EXT_AW-1:0];
            page_q     <= page_q + PAGE_W'(ext_next[EXT_AW]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_addr_q   <= '0;
            words_left_q <= CNT_W'(BOOT_WORDS);
        end else if (word_step) begin
            int_addr_q   <= int_addr_q + 1'b1;
            words_left_q <= words_left_q - 1'b1;
        end
    end

endmodule

// File: rtl/boot_seq_top.sv
module boot_seq_top
    import boot_seq_pkg::*;
#(
    parameter int EXT_AW     = 14,
    parameter int PAGE_W     = 8,
    parameter int PM_AW      = 14,
    parameter int BYTE_W     = 8,
    parameter int WORD_W     = 24,
    parameter int BOOT_WORDS = 32,
    localparam int BM_AW     = PAGE_W + EXT_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_pins,
    output logic              bm_rd_en,
    output logic [BM_AW-1:0]  bm_addr,
    input  logic [BYTE_W-1:0] bm_rd_data,
    input  logic              bm_rd_valid,
    output logic              pm_wr_en,
    output logic [PM_AW-1:0]  pm_wr_addr,
    output logic [WORD_W-1:0] pm_wr_data,
    input  logic              host_wr_en,
    input  logic [PM_AW-1:0]  host_wr_addr,
    output logic              core_hold
);

    boot_state_e       state_q, state_n;
    boot_kind_e        kind_q;
    logic              last_byte, last_word;
    logic              byte_step, word_step, host_hit;
    logic [PAGE_W-1:0] page_q;
    logic [EXT_AW-1:0] ext_addr_q;

    assign host_hit  = host_wr_en && (host_wr_addr == '0);
    assign byte_step = (state_q == ST_BYTE_WAIT) && bm_rd_valid;
    assign word_step = (state_q == ST_WORD_WRITE);

    boot_mode_capture u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_en(state_q == ST_SAMPLE),
        .mode_pins(mode_pins),
        .kind_q   (kind_q)
    );

    boot_byte_packer #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (byte_step),
        .byte_in  (bm_rd_data),
        .word_out (pm_wr_data),
        .last_byte(last_byte)
    );

    boot_dma_regs #(
        .EXT_AW(EXT_AW), .PAGE_W(PAGE_W), .PM_AW(PM_AW), .BOOT_WORDS(BOOT_WORDS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_step (byte_step),
        .word_step (word_step),
        .page_q    (page_q),
        .ext_addr_q(ext_addr_q),
        .int_addr_q(pm_wr_addr),
        .last_word (last_word)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_SAMPLE;
        else
            state_q <= state_n;
    end

    // transitions
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_SAMPLE:   state_n = ST_DISPATCH;
            ST_DISPATCH: begin
                unique case (kind_q)
                    BOOT_BYTE: state_n = ST_BYTE_REQ;
                    BOOT_HOST: state_n = host_hit ? ST_RUN : ST_HOST_WAIT;
                    default:   state_n = ST_RUN;
                endcase
            end
            ST_BYTE_REQ:  state_n = ST_BYTE_WAIT;
            ST_BYTE_WAIT: begin
                if (bm_rd_valid)
                    state_n = last_byte ? ST_WORD_WRITE : ST_BYTE_REQ;
            end
            ST_WORD_WRITE: state_n = last_word ? ST_RUN : ST_BYTE_REQ;
            ST_HOST_WAIT: begin
                if (host_hit)
                    state_n = ST_RUN;
            end
            ST_RUN:  state_n = ST_RUN;
            default: state_n = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        bm_rd_en  = 1'b0;
        pm_wr_en  = 1'b0;
        core_hold = 1'b1;
        unique case (state_q)
            ST_BYTE_REQ:   bm_rd_en  = 1'b1;
            ST_WORD_WRITE: pm_wr_en  = 1'b1;
            ST_RUN:        core_hold = 1'b0;
            default:       ;
        endcase
    end

    assign bm_addr = {page_q, ext_addr_q};

endmodule

// File: rtl/boot_seq_checker.sv
module boot_seq_checker #(
    parameter int PM_AW      = 14,
    parameter int BM_AW      = 22,
    parameter int BOOT_WORDS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       mode_pins,
    input logic             bm_rd_en,
    input logic [BM_AW-1:0] bm_addr,
    input logic             pm_wr_en,
    input logic [PM_AW-1:0] pm_wr_addr,
    input logic             core_hold
);

    logic             seen_q;
    logic [2:0]       cap_q;
    logic [31:0]      wr_cnt;
    logic [BM_AW-1:0] rd_cnt;
    logic             host_mode, none_mode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            cap_q  <= 3'b000;
            wr_cnt <= '0;
            rd_cnt <= '0;
        end else begin
            if (!seen_q) begin
                seen_q <= 1'b1;
                cap_q  <= mode_pins;
            end
            if (pm_wr_en) wr_cnt <= wr_cnt + 1;
            if (bm_rd_en) rd_cnt <= rd_cnt + 1'b1;
        end
    end

    assign host_mode = seen_q && (cap_q == 3'b101);
    assign none_mode = seen_q && (cap_q[2] || cap_q[0]) && (cap_q != 3'b101);

    assert_hold_latched_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !core_hold |=> !core_hold);

    assert_write_under_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pm_wr_en |-> core_hold);

    assert_one_outstanding_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bm_rd_en |=> !bm_rd_en);

    assert_write_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pm_wr_en |-> ((32'(pm_wr_addr) == wr_cnt) && (wr_cnt < BOOT_WORDS)));

    assert_read_sequence_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bm_rd_en |-> (bm_addr == rd_cnt));

    assert_host_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        host_mode |-> (!pm_wr_en && !bm_rd_en));

    assert_none_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        none_mode |=> (!core_hold && !pm_wr_en && !bm_rd_en));

endmodule

bind boot_seq_top boot_seq_checker #(
    .PM_AW(PM_AW), .BM_AW(BM_AW), .BOOT_WORDS(BOOT_WORDS)
) u_boot_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_pins (mode_pins),
    .bm_rd_en  (bm_rd_en),
    .bm_addr   (bm_addr),
    .pm_wr_en  (pm_wr_en),
    .pm_wr_addr(pm_wr_addr),
    .core_hold (core_hold)
);

// File: tb/boot_seq_top_test.sv
module boot_seq_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int NWORDS     = 32;
    localparam int NBYTES     = 3 * NWORDS;

    // {mode[2:0], kind[1:0]}: kind 0 byte, 1 host, 2 none
    localparam logic [4:0] VEC [8] = '{
        {3'b000, 2'd0}, {3'b001, 2'd2}, {3'b010, 2'd0}, {3'b011, 2'd2},
        {3'b100, 2'd2}, {3'b101, 2'd1}, {3'b110, 2'd2}, {3'b111, 2'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode_pins = 3'b000;
    logic        bm_rd_en;
    logic [21:0] bm_addr;
    logic [7:0]  bm_rd_data;
    logic        bm_rd_valid;
    logic        pm_wr_en;
    logic [13:0] pm_wr_addr;
    logic [23:0] pm_wr_data;
    logic        host_wr_en = 1'b0;
    logic [13:0] host_wr_addr = '0;
    logic        core_hold;

    int checks = 0;
    int failures = 0;
    int cyc;
    int lat_extra = 0;
    bit finished = 0;

    boot_seq_top uut (
        .clk(clk), .rst_n(rst_n), .mode_pins(mode_pins),
        .bm_rd_en(bm_rd_en), .bm_addr(bm_addr), .bm_rd_data(bm_rd_data),
        .bm_rd_valid(bm_rd_valid), .pm_wr_en(pm_wr_en), .pm_wr_addr(pm_wr_addr),
        .pm_wr_data(pm_wr_data), .host_wr_en(host_wr_en),
        .host_wr_addr(host_wr_addr), .core_hold(core_hold)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] bdata(input int a);
        return 8'((a * 37 + 5) & 255);
    endfunction

    always @(posedge clk or negedge rst_n)
        if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

    // boot memory model
    logic [21:0] pend;
    int          dly;
    logic        busy;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bm_rd_valid <= 1'b0; bm_rd_data <= '0; busy <= 1'b0; dly <= 0; pend <= '0;
        end else begin
            bm_rd_valid <= 1'b0;
            if (bm_rd_en) begin
                pend <= bm_addr; dly <= lat_extra; busy <= 1'b1;
            end else if (busy) begin
                if (dly == 0) begin
                    bm_rd_valid <= 1'b1; bm_rd_data <= bdata(int'(pend)); busy <= 1'b0;
                end else dly <= dly - 1;
            end
        end
    end

    // monitor
    int          nwr, nrd, rd_bad, last_wr_cyc;
    logic [13:0] wa [64];
    logic [23:0] wd [64];
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nwr <= 0; nrd <= 0; rd_bad <= 0; last_wr_cyc <= -1;
        end else begin
            if (pm_wr_en) begin
                if (nwr < 64) begin wa[nwr] <= pm_wr_addr; wd[nwr] <= pm_wr_data; end
                nwr <= nwr + 1;
                last_wr_cyc <= cyc;
            end
            if (bm_rd_en) begin
                if (int'(bm_addr) != nrd) rd_bad <= rd_bad + 1;
                nrd <= nrd + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] m);
        @(negedge clk);
        rst_n = 1'b0; host_wr_en = 1'b0; mode_pins = 3'b111;
        repeat (2) @(negedge clk);
        check(core_hold === 1'b1, "R3 hold in reset", int'(core_hold), 1);
        check(bm_rd_en === 1'b0 && pm_wr_en === 1'b0, "R3 quiet in reset",
              int'({bm_rd_en, pm_wr_en}), 0);
        mode_pins = m;  // value present at the release edge
        rst_n = 1'b1;
    endtask

    task automatic wait_release(input int limit, output int fall_cyc);
        fall_cyc = -1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (core_hold === 1'b0) begin fall_cyc = cyc; break; end
        end
    endtask

    task automatic run_byte(input logic [2:0] m, input int lat, input bit flip_pins);
        int fc;
        lat_extra = lat;
        do_reset(m);
        if (flip_pins) begin
            repeat (5) @(negedge clk);
            mode_pins = 3'b101;  // R1: change after capture
        end
        wait_release(2000, fc);
        check(fc >= 0, "R7 byte boot releases", fc, 1);
        check(nrd == NBYTES, "R4 read count", nrd, NBYTES);
        check(rd_bad == 0, "R4 read address order", rd_bad, 0);
        check(nwr == NWORDS, flip_pins ? "R1 pins ignored, R6 write count" : "R6 write count",
              nwr, NWORDS);
        for (int i = 0; i < NWORDS && i < nwr; i++) begin
            logic [23:0] exp_w;
            exp_w = {bdata(3*i), bdata(3*i+1), bdata(3*i+2)};
            check(int'(wa[i]) == i, "R6 write address", int'(wa[i]), i);
            check(wd[i] == exp_w, "R5 word packing", int'(wd[i]), int'(exp_w));
        end
        check(fc == last_wr_cyc + 1, "R7 release timing", fc, last_wr_cyc + 1);
        // R10: host write to 0 after release has no effect
        host_wr_addr = '0; host_wr_en = 1'b1;
        @(negedge clk);
        host_wr_en = 1'b0;
        repeat (8) @(negedge clk);
        check(core_hold === 1'b0, "R10 hold stays low", int'(core_hold), 0);
        check(nwr == NWORDS && nrd == NBYTES, "R10 no traffic after release",
              nwr + nrd, NWORDS + NBYTES);
    endtask

    task automatic run_host(input logic [2:0] m);
        do_reset(m);
        repeat (3) @(negedge clk);
        mode_pins = 3'b000;  // R1: change after capture
        for (int k = 0; k < 5; k++) begin
            host_wr_addr = 14'(7 - k); host_wr_en = 1'b1;  // addresses 7..3
            @(negedge clk);
        end
        host_wr_en = 1'b0;
        repeat (3) @(negedge clk);
        check(core_hold === 1'b1, "R8 hold through non-zero host writes", int'(core_hold), 1);
        check(nwr == 0 && nrd == 0, "R8 no own traffic", nwr + nrd, 0);
        check(core_hold === 1'b1, "R1 pins changed after capture", int'(core_hold), 1);
        host_wr_addr = '0; host_wr_en = 1'b1;
        @(negedge clk);
        host_wr_en = 1'b0;
        check(core_hold === 1'b0, "R8 release after write to 0", int'(core_hold), 0);
    endtask

    task automatic run_none(input logic [2:0] m);
        do_reset(m);
        @(negedge clk);
        check(core_hold === 1'b1, "R9 held after first edge", int'(core_hold), 1);
        @(negedge clk);
        check(core_hold === 1'b0, "R9 release after second edge", int'(core_hold), 0);
        repeat (5) @(negedge clk);
        check(nwr == 0 && nrd == 0, "R9 no traffic", nwr + nrd, 0);
    endtask

    initial begin
        // R2: walk every encoding
        for (int i = 0; i < 8; i++) begin
            logic [2:0] m;
            logic [1:0] k;
            m = VEC[i][4:2];
            k = VEC[i][1:0];
            if (k == 2'd0)      run_byte(m, i % 3, 1'b0);
            else if (k == 2'd1) run_host(m);
            else                run_none(m);
        end
        // directed corners
        run_byte(3'b010, 2, 1'b1);   // R1, R11 with slow memory
        run_byte(3'b000, 0, 1'b0);   // R11 fastest response
        // R8: write to 0 on the second edge after release
        do_reset(3'b101);
        host_wr_addr = '0; host_wr_en = 1'b1;
        @(negedge clk);
        host_wr_en = 1'b0;
        check(core_hold === 1'b1, "R8 write on first edge ignored", int'(core_hold), 1);
        host_wr_en = 1'b1;
        @(negedge clk);
        host_wr_en = 1'b0;
        check(core_hold === 1'b0, "R8 write on second edge releases", int'(core_hold), 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule